// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block works out the column address for every beat of an SDRAM read or write burst. A controller pulses a start strobe together with the first column, a burst-length code and an ordering bit. From the next cycle on, the block presents one column per clock with a beat-valid flag. It raises a last-beat flag on the final beat of a fixed-length burst and then goes idle.

Fixed bursts of two, four or eight beats stay inside an aligned block of that many columns. The ordering is either sequential, wrapping back to the start of the block, or interleaved, where the offset is the starting offset XOR the beat number. A full-page burst counts up through the row, wraps at the top and runs until a stop strobe ends it. A full-page request with interleaved ordering is refused: an error flag pulses and no beats are issued. The block does not drive command pins, carry data, track banks or model read latency.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `beat_vld_o`, `beat_last_o` and `err_o` are low.
- R2: `len_i` encodes 0 = two beats, 1 = four, 2 = eight, 3 = full page. `ilv_i` = 0 selects sequential ordering and 1 selects interleaved. The cycle after an accepted start strobe shows `beat_vld_o` high and `col_o` equal to the starting column.
- R3: During a fixed burst of 2^k beats, the column bits at position k and above stay those of the starting column.
- R4: With sequential ordering, beat i of a fixed burst of length L has low offset (start offset + i) mod L. A length-4 burst starting at offset 1 gives 1,2,3,0.
- R5: With interleaved ordering, beat i has low offset (start offset XOR i). A length-8 burst starting at offset 5 gives 5,4,7,6,1,0,3,2.
- R6: A fixed burst issues exactly L beats on consecutive cycles. `beat_last_o` is high on the final beat only, and `beat_vld_o` is low on the cycle after it.
- R7: A full-page burst steps the column by one each cycle modulo 2^COL_W, never raises `beat_last_o`, and continues until stopped.
- R8: A stop strobe seen with a beat on the outputs makes the following cycle idle, for both full-page and fixed bursts. A stop strobe while idle has no effect.
- R9: A start with `len_i` = 3 and `ilv_i` = 1 pulses `err_o` for exactly one cycle with `beat_vld_o` low. No beats follow, and any burst in progress is abandoned.
- R10: A start strobe during a burst restarts it from the new column on the next cycle. A start takes priority over a stop in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a burst this cycle |
| start_col_i | input | COL_W | First column of the burst |
| len_i | input | 2 | Burst-length code |
| ilv_i | input | 1 | Ordering: 0 sequential, 1 interleaved |
| stop_i | input | 1 | End the current burst |
| col_o | output | COL_W | Column of the current beat |
| beat_vld_o | output | 1 | A beat is on `col_o` |
| beat_last_o | output | 1 | Final beat of a fixed burst |
| err_o | output | 1 | Illegal length/ordering request seen |

## Verification
The bench sweeps every start offset of the eight-beat burst under both orderings. A design that adds instead of XORing, or lets the carry climb into the block bits, produces wrong columns from the wrap point onward. A full-page burst is started three columns below the top of the row, so a design that saturates or stalls at the row end is caught. Stops are sent mid-burst and while idle, so a design that ignores stop or takes an extra beat shows surplus beats. A restart is sent with a stop in the same cycle, and the illegal combination is sent both while idle and during a burst, so a design that lets stop win or keeps streaming after the error shows stray or missing beats.

// File: rtl/burst_pkg.sv
package burst_pkg;

  typedef enum logic [1:0] {
    BL_TWO   = 2'd0,
    BL_FOUR  = 2'd1,
    BL_EIGHT = 2'd2,
    BL_PAGE  = 2'd3
  } blen_e;

  // log2 of the aligned block size; 0 marks the open-ended page mode
  function automatic int unsigned span_log2(blen_e code);
    case (code)
      BL_TWO:   return 1;
      BL_FOUR:  return 2;
      BL_EIGHT: return 3;
      default:  return 0;
    endcase
  endfunction

endpackage

// File: rtl/burst_addr_calc.sv
module burst_addr_calc
  import burst_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] idx_i,
  input  blen_e            len_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o,
  output logic [COL_W-1:0] blk_mask_o
);

  // mask of the bits that move inside one burst
  function automatic logic [COL_W-1:0] move_mask(blen_e code);
    if (code == BL_PAGE) return '1;
    return (COL_W'(1) << span_log2(code)) - COL_W'(1);
  endfunction

  // fixed high bits of base, moving low bits from add or XOR
  function automatic logic [COL_W-1:0] form_col(
    logic [COL_W-1:0] base,
    logic [COL_W-1:0] idx,
    logic [COL_W-1:0] m,
    logic             xor_order
  );
    logic [COL_W-1:0] off;
    off = xor_order ? (base ^ idx) : (base + idx);
    return (base & ~m) | (off & m);
  endfunction

  always_comb begin
    blk_mask_o = move_mask(len_i);
    col_o      = form_col(base_i, idx_i, blk_mask_o, ilv_i && (len_i != BL_PAGE));
  end

endmodule

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl
  import burst_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  blen_e            len_i,
  input  logic             ilv_i,
  input  logic             stop_i,
  output logic             active_o,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] idx_o,
  output blen_e            len_o,
  output logic             ilv_o,
  output logic             last_o,
  output logic             err_o
);

  logic             active_q;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] idx_q;
  blen_e            len_q;
  logic             ilv_q;
  logic             err_q;

  // named events, visible to the assertions
  logic             ev_illegal;
  logic             ev_launch;
  logic             ev_finish;
  logic             ev_halt;
  logic [COL_W-1:0] term_idx;

  always_comb begin
    term_idx   = (COL_W'(1) << span_log2(len_q)) - COL_W'(1);
    ev_illegal = start_i && (len_i == BL_PAGE) && ilv_i;
    ev_launch  = start_i && !ev_illegal;
    last_o     = active_q && (len_q != BL_PAGE) && (idx_q == term_idx);
    ev_finish  = !start_i && last_o;
    ev_halt    = active_q && !start_i && stop_i && !ev_finish;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      base_q   <= '0;
      idx_q    <= '0;
      len_q    <= BL_TWO;
      ilv_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      err_q <= ev_illegal;
      if (ev_launch) begin
        active_q <= 1'b1;
        base_q   <= start_col_i;
        idx_q    <= '0;
        len_q    <= len_i;
        ilv_q    <= ilv_i;
      end else if (ev_illegal || ev_finish || ev_halt) begin
        active_q <= 1'b0;
      end else if (active_q) begin
        idx_q <= idx_q + COL_W'(1);
      end
    end
  end

  assign active_o = active_q;
  assign base_o   = base_q;
  assign idx_o    = idx_q;
  assign len_o    = len_q;
  assign ilv_o    = ilv_q;
  assign err_o    = err_q;

  AST_ERR_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !active_o); // R9
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !ev_illegal) |=> !err_o); // R9
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !start_i) |=> !active_o); // R6
  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && stop_i && !start_i) |=> !active_o); // R8
  AST_START_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_launch && stop_i) |=> (active_o && idx_o == '0)); // R10

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [1:0]       len_i,
  input  logic             ilv_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             beat_vld_o,
  output logic             beat_last_o,
  output logic             err_o
);

  initial begin
    if (COL_W < 3) $error("COL_W must hold an eight-beat block");
  end

  logic [COL_W-1:0] base_w;
  logic [COL_W-1:0] idx_w;
  blen_e            len_w;
  logic             ilv_w;
  logic [COL_W-1:0] blk_mask_w;
  logic             page_w;

  burst_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .len_i       (blen_e'(len_i)),
    .ilv_i       (ilv_i),
    .stop_i      (stop_i),
    .active_o    (beat_vld_o),
    .base_o      (base_w),
    .idx_o       (idx_w),
    .len_o       (len_w),
    .ilv_o       (ilv_w),
    .last_o      (beat_last_o),
    .err_o       (err_o)
  );

  burst_addr_calc #(.COL_W(COL_W)) u_calc (
    .base_i     (base_w),
    .idx_i      (idx_w),
    .len_i      (len_w),
    .ilv_i      (ilv_w),
    .col_o      (col_o),
    .blk_mask_o (blk_mask_w)
  );

  assign page_w = beat_vld_o && (len_w == BL_PAGE);

  AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !(len_i == 2'd3 && ilv_i)) |=> (beat_vld_o && col_o == $past(start_col_i))); // R2
  AST_BLOCK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_vld_o && !page_w && !beat_last_o && !start_i && !stop_i)
      |=> ((col_o & ~blk_mask_w) == ($past(col_o) & ~$past(blk_mask_w)))); // R3
  AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (page_w && !start_i && !stop_i) |=> (col_o == $past(col_o) + COL_W'(1))); // R7
  AST_LAST_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last_o |-> (beat_vld_o && !page_w)); // R6

endmodule

// File: tb/tb_burst_col_gen.sv
module tb_burst_col_gen;

  localparam int W = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [W-1:0] start_col_i = '0;
  logic [1:0]   len_i = 2'd0;
  logic         ilv_i = 1'b0;
  logic         stop_i = 1'b0;
  logic [W-1:0] col_o;
  logic         beat_vld_o;
  logic         beat_last_o;
  logic         err_o;

  int vectors = 0;
  int miscompares = 0;

  logic [W:0] exp_q[$];   // {last, col}
  string      tag_q[$];

  burst_col_gen #(.COL_W(W)) dut (
    .clk, .rst_n, .start_i, .start_col_i, .len_i, .ilv_i, .stop_i,
    .col_o, .beat_vld_o, .beat_last_o, .err_o
  );

  always #5 clk = ~clk;

  function automatic int beats_of(logic [1:0] code);
    return (code == 2'd3) ? (1 << W) : (2 << code);
  endfunction

  // independent model: block arithmetic by division and modulo
  function automatic logic [W-1:0] model_col(int base, int i, logic [1:0] code, logic ilv);
    int len, blk, off;
    if (code == 2'd3) return W'((base + i) % (1 << W));
    len = beats_of(code);
    blk = (base / len) * len;
    off = ilv ? ((base % len) ^ i) : (((base % len) + i) % len);
    return W'(blk + off);
  endfunction

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pop and compare each beat
  always @(negedge clk) begin
    if (rst_n && beat_vld_o) begin
      if (exp_q.size() == 0) begin
        check("R6/R8 stray beat", 1, 0);
      end else begin
        logic [W:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {beat_last_o, col_o}, e);
      end
    end
  end

  // push n expected beats; cut=0 means natural end
  task automatic push_beats(int col, logic [1:0] code, logic ilv, int n, string tag);
    for (int i = 0; i < n; i++) begin
      logic lst;
      lst = (code != 2'd3) && (i == beats_of(code) - 1);
      exp_q.push_back({lst, model_col(col, i, code, ilv)});
      tag_q.push_back(tag);
    end
  endtask

  // called at a negedge; returns at the negedge after the burst is over
  task automatic burst(int col, logic [1:0] code, logic ilv, int cut, string tag);
    int n;
    n = (cut > 0) ? cut : beats_of(code);
    push_beats(col, code, ilv, n, tag);
    start_i = 1'b1; start_col_i = W'(col); len_i = code; ilv_i = ilv;
    @(negedge clk);
    start_i = 1'b0; stop_i = 1'b0;
    if (cut > 0) begin
      repeat (cut - 1) @(negedge clk);
      stop_i = 1'b1;
      @(negedge clk);
      stop_i = 1'b0;
    end else begin
      repeat (n) @(negedge clk);
    end
  endtask

  task automatic drain(string tag);
    repeat (2) @(negedge clk);
    check({tag, " idle after burst"}, beat_vld_o, 0);
    check({tag, " queue drained"}, exp_q.size(), 0);
    exp_q.delete(); tag_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid in reset", beat_vld_o, 0);
    check("R1 err in reset", err_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", beat_vld_o, 0);
    check("R1 last after reset", beat_last_o, 0);

    // R2/R4 sequential short bursts
    burst(10'h0A5, 2'd0, 1'b0, 0, "R2 R4 seq len2");  drain("R6");
    burst(10'h131, 2'd1, 1'b0, 0, "R4 seq len4 off1"); drain("R6");
    // R5 interleaved short bursts
    burst(10'h0A5, 2'd0, 1'b1, 0, "R5 ilv len2");     drain("R6");
    burst(10'h236, 2'd1, 1'b1, 0, "R5 ilv len4");     drain("R6");
    // R3/R4/R5 every offset of an eight-beat block
    for (int t = 0; t < 2; t++) begin
      for (int off = 0; off < 8; off++) begin
        burst(10'h1C8 + off, 2'd2, t[0], 0, t == 0 ? "R3 R4 seq len8" : "R3 R5 ilv len8");
      end
    end
    drain("R6");

    // R7 full page crossing the top of the row, stopped (R8)
    burst(10'h3FD, 2'd3, 1'b0, 6, "R7 page wrap");  drain("R8");
    // R8 stop inside a fixed burst
    burst(10'h040, 2'd2, 1'b1, 3, "R8 stop len8");  drain("R8");
    // R8 stop while idle: nothing happens
    stop_i = 1'b1; @(negedge clk); stop_i = 1'b0; @(negedge clk);
    check("R8 stop idle", beat_vld_o, 0);

    // R10 restart with a simultaneous stop
    push_beats(10'h080, 2'd2, 1'b0, 3, "R10 first burst");
    start_i = 1'b1; start_col_i = 10'h080; len_i = 2'd2; ilv_i = 1'b0;
    @(negedge clk); start_i = 1'b0;
    repeat (2) @(negedge clk);
    stop_i = 1'b1;
    burst(10'h2F3, 2'd1, 1'b0, 0, "R10 restarted");
    drain("R10");

    // R9 illegal while idle
    start_i = 1'b1; start_col_i = 10'h100; len_i = 2'd3; ilv_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    check("R9 err pulse", err_o, 1);
    check("R9 no beat", beat_vld_o, 0);
    @(negedge clk);
    check("R9 err one cycle", err_o, 0);
    check("R9 still idle", beat_vld_o, 0);

    // R9 illegal during a burst abandons it
    push_beats(10'h300, 2'd2, 1'b0, 2, "R9 before abort");
    start_i = 1'b1; start_col_i = 10'h300; len_i = 2'd2; ilv_i = 1'b0;
    @(negedge clk); start_i = 1'b0;
    @(negedge clk);
    start_i = 1'b1; len_i = 2'd3; ilv_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    check("R9 abort err", err_o, 1);
    check("R9 abort no beat", beat_vld_o, 0);
    drain("R9");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule